// File: doc/BRIEF.md
# Serial PHY Management Register Controller

This block gives a host a memory-mapped path to the management registers of an Ethernet PHY over the two-wire management bus (clock plus bidirectional data). The host packs a complete transaction into one 32-bit word and writes it to the command register. The word carries the operation, the PHY address, the register number and, for a write, the data. The controller then produces a clause-22 serial frame on the management clock and data pins.

The host polls the same register. A busy flag stays up for the whole frame. When a read completes, a read-valid flag rises and the low half of the register holds the value that the PHY returned. A second, independent register holds the port's own 5-bit PHY address for software to keep.

The management clock is derived from the system clock by a parameterised divider. Data is launched on the falling edge of the management clock and sampled on its rising edge.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command register reads 0, the own-address register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: The command register is laid out as follows. Data is in bits [15:0]. The PHY address is in [20:16] and the register number is in [25:21]. The opcode is bit 26, where 1 means read and 0 means write. Read-valid is bit 27 and busy is bit 28. Bits [31:29] read as 0. An accepted command reads back with its fields as written.
- R3: A write command produces 64 bits, MSB first, each valid at a rising edge of `mdc` with `mdio_oe` high. The bits are 32 ones, start `01`, opcode `01`, the PHY address, the register number, turnaround `10`, and the 16 data bits.
- R4: A read command produces the same first 14 bits with opcode `10`. `mdio_oe` is then low for the remaining 18 bits. The 16 bits sampled from `mdio_i` at the last 16 rising edges form the read data, MSB first.
- R5: Busy is set in the cycle after a command is accepted and stays set until the frame ends. It then clears and `mdc` is held low.
- R6: After a read completes, read-valid is 1 and the data field holds the value returned by the PHY. After a write completes, read-valid stays 0.
- R7: A command written while busy is set is ignored. The register fields do not change and the frame in progress is not altered.
- R8: Writing an accepted command clears read-valid.
- R9: The own-address register (bus address 1) stores bits [4:0] of the written word, reads back zero-extended, and can be written at any time without affecting a transaction.
- R10: The `mdc` period is 2×`DIV_HALF` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 command, 1 own address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The collision of interest is a host command write landing in the same cycle as frame completion. At that point the read result is loaded into the data field while the write must still be rejected, because busy is still set.

The bench provokes this by writing a junk command on every cycle in which the polled busy flag reads as set, all the way through the end of a read frame. It then judges the outcome in three ways:
- The data field holds the PHY reply.
- Read-valid is set and the address fields are those of the original command.
- The frame scoreboard sees no extra frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;
  localparam int RDATA_IDX  = 48;

  localparam int F_PHY_LSB = 16;
  localparam int F_REG_LSB = 21;
  localparam int F_OP_BIT  = 26;
  localparam int F_RV_BIT  = 27;
  localparam int F_BSY_BIT = 28;

  typedef struct packed {
    logic       op_read;
    logic [4:0] regad;
    logic [4:0] phy;
    logic [15:0] data;
  } mgmt_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [1:0] opc;
    logic [1:0] ta;
    opc = c.op_read ? 2'b10 : 2'b01;
    ta  = c.op_read ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.regad, ta,
            (c.op_read ? 16'hFFFF : c.data)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term     = run && (cnt_q == TERM);
  assign rise_stb = term && !mdc_q;
  assign fall_stb = term && mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  AST_RISE_GOES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc); // R10
  AST_FALL_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc); // R10
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc); // R5
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [15:0]           cap_q, cap_d;

  assign busy    = busy_q;
  assign done    = busy_q && fall_stb && (idx_q == LAST);
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IW'(TA_IDX)));
  assign rd_data = cap_q;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    cap_d  = cap_q;
    if (start) begin
      sh_d   = build_frame(cmd);
      idx_d  = '0;
      busy_d = 1'b1;
      rd_d   = cmd.op_read;
    end else if (busy_q) begin
      if (fall_stb) begin
        if (idx_q == LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + IW'(1);
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
      if (rise_stb && rd_q && (idx_q >= IW'(RDATA_IDX))) begin
        cap_d = {cap_q[14:0], mdio_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      cap_q  <= cap_d;
    end
  end

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R5
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_cmd_t   cmd_q, cmd_d, new_cmd;
  logic        rv_q, rv_d;
  logic [4:0]  own_q, own_d;
  logic        busy, done, start;
  logic        rise_stb, fall_stb;
  logic [15:0] rd_data;

  assign new_cmd.data    = bus_wdata[15:0];
  assign new_cmd.phy     = bus_wdata[F_PHY_LSB +: 5];
  assign new_cmd.regad   = bus_wdata[F_REG_LSB +: 5];
  assign new_cmd.op_read = bus_wdata[F_OP_BIT];

  assign start = bus_wr && !bus_addr && !busy;

  always_comb begin
    cmd_d = cmd_q;
    rv_d  = rv_q;
    own_d = own_q;
    if (start) begin
      cmd_d = new_cmd;
      rv_d  = 1'b0;
    end else if (done && cmd_q.op_read) begin
      cmd_d.data = rd_data;
      rv_d       = 1'b1;
    end
    if (bus_wr && bus_addr) begin
      own_d = bus_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      rv_q  <= 1'b0;
      own_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      rv_q  <= rv_d;
      own_q <= own_d;
    end
  end

  always_comb begin
    if (bus_addr) begin
      bus_rdata = {27'd0, own_q};
    end else begin
      bus_rdata = {3'd0, busy, rv_q, cmd_q.op_read, cmd_q.regad,
                   cmd_q.phy, cmd_q.data};
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd_q.op_read ? cmd_d : new_cmd),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data)
  );

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R5
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && busy && !done) |=> $stable(cmd_q)); // R7
  AST_RVALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> !busy); // R6
  AST_START_CLEARS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rv_q); // R8
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
  localparam int DIV_HALF = 2;

  logic        clk, rst_n, bus_wr, bus_addr, mdio_i;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0]  exp_q[$];   // {oe_expected, value_expected}
  int          bitpos = 0;
  logic [15:0] reply = 16'h0;

  mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: pop scoreboard at each management clock rise
  always @(posedge mdc) begin
    #1;
    if (exp_q.size() == 0) begin
      chk("R3/R4 unexpected mdc edge", 32'd1, 32'd0);
    end else begin
      logic [1:0] e;
      e = exp_q.pop_front();
      chk("R3/R4 oe", {31'd0, mdio_oe}, {31'd0, e[1]});
      if (e[1]) chk("R3/R4 bit", {31'd0, mdio_o}, {31'd0, e[0]});
    end
    bitpos++;
  end

  // PHY responder: present reply data after each fall
  always @(negedge mdc) begin
    if (bitpos >= 48 && bitpos < 64) mdio_i = reply[63 - bitpos];
    else mdio_i = 1'b1;
  end

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 1'b0;
  endtask

  function automatic logic [31:0] pack(input logic op, input logic [4:0] ph,
                                       input logic [4:0] rg, input logic [15:0] d);
    return {5'd0, op, rg, ph, d};
  endfunction

  // driver: push expected frame, then issue the command
  task automatic send_cmd(input logic op, input logic [4:0] ph, input logic [4:0] rg,
                          input logic [15:0] d, input logic [15:0] rep);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (op ? 2'b10 : 2'b01), ph, rg,
         (op ? 2'b11 : 2'b10), d};
    reply  = rep;
    bitpos = 0;
    for (int k = 0; k < 64; k++) begin
      logic oe_e;
      oe_e = !(op && k >= 46);
      exp_q.push_back({oe_e, f[63-k]});
    end
    bus_write(1'b0, pack(op, ph, rg, d));
  endtask

  // poll busy; optionally hammer junk commands whenever busy reads set (R7)
  task automatic wait_idle(input bit hammer);
    logic [31:0] r;
    int guard;
    guard = 0;
    forever begin
      @(negedge clk);
      bus_wr = 1'b0;
      bus_read(1'b0, r);
      if (!r[28]) break;
      if (hammer) begin
        bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = 32'h07FF_FFFF ^ guard;
      end
      guard++;
      if (guard > 5000) begin
        chk("R5 busy never cleared", 32'd1, 32'd0);
        break;
      end
    end
    bus_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    time t0, t1;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; mdio_i = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(1'b0, r); chk("R1 cmd reg", r, 32'h0);
    bus_read(1'b1, r); chk("R1 own reg", r, 32'h0);
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);

    // R9 own-address register
    bus_write(1'b1, 32'h0000_0013);
    bus_read(1'b1, r); chk("R9 own write", r, 32'h13);
    bus_write(1'b1, 32'hFFFF_FFFF);
    bus_read(1'b1, r); chk("R9 own width", r, 32'h1F);

    // R2/R3/R5 write transaction
    send_cmd(1'b0, 5'h05, 5'h1A, 16'hA5C3, 16'h0);
    bus_read(1'b0, r);
    chk("R2 readback", r, 32'h1000_0000 | pack(1'b0, 5'h05, 5'h1A, 16'hA5C3));
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    chk("R10 mdc period", 32'(t1 - t0), 32'(2 * DIV_HALF * 20));
    // R7 ignored command, R9 own write mid-frame
    bus_write(1'b0, pack(1'b1, 5'h1F, 5'h00, 16'h1234));
    bus_write(1'b1, 32'h0000_000A);
    bus_read(1'b0, r);
    chk("R7 fields kept", r, 32'h1000_0000 | pack(1'b0, 5'h05, 5'h1A, 16'hA5C3));
    bus_read(1'b1, r); chk("R9 own during busy", r, 32'h0A);
    wait_idle(1'b0);
    bus_read(1'b0, r);
    chk("R6 write done no rvalid", r, pack(1'b0, 5'h05, 5'h1A, 16'hA5C3));
    chk("R5 mdc idle low", {31'd0, mdc}, 32'd0);
    chk("R3 all bits seen", 32'(exp_q.size()), 32'd0);

    // R4/R6 read with junk commands hammered through completion
    send_cmd(1'b1, 5'h11, 5'h02, 16'h0000, 16'h3C96);
    wait_idle(1'b1);
    repeat (4) @(negedge clk);
    bus_read(1'b0, r);
    chk("R6 read result", r, 32'h0800_0000 | pack(1'b1, 5'h11, 5'h02, 16'h3C96));
    chk("R4 all bits seen", 32'(exp_q.size()), 32'd0);

    // R8 new command clears read-valid
    send_cmd(1'b0, 5'h00, 5'h1F, 16'h0F0F, 16'h0);
    bus_read(1'b0, r);
    chk("R8 rvalid cleared", {29'd0, r[28:26]}, 32'b100);
    wait_idle(1'b0);

    // R4 second read pattern
    send_cmd(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h8001);
    wait_idle(1'b0);
    bus_read(1'b0, r);
    chk("R4 read edge bits", r, 32'h0800_0000 | pack(1'b1, 5'h1F, 5'h1F, 16'h8001));
    bus_read(1'b1, r); chk("R9 own retained", r, 32'h0A);
    chk("R4 queue empty", 32'(exp_q.size()), 32'd0);

    repeat (10) @(negedge clk);
    chk("R5 no stray frame", 32'(bitpos), 32'd64);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule